// File: doc/BRIEF.md
# Tape Command and Interrupt Register

This block is the command register that software writes to start a magnetic tape controller and reads to see where the controller stands. A single 16-bit write supplies these fields: the target unit, the formatter select, the operation code, the start strobe (GO), the interrupt enable, a power-clear strobe and two extended address bits. The block keeps the controller-ready flag and a sticky error flag. It turns an accepted GO into a one-cycle start pulse that carries the operation code, the unit and the formatter.

The same block owns the interrupt request. There is one request, and it stays pending until it is acknowledged. It is raised when ready or error turns on, when a rewinding unit reports beginning-of-tape, or when software arms the enable while the controller already has something to report. The tape motion and the bus handshakes sit outside this block. It sees only a completion pulse, a status error vector and per-unit beginning-of-tape pulses.

Top module: `tape_cmd_ctl`

## Requirements
- R1: After reset or an `init` pulse, the read value is 16'h0080: ready is 1 and every other field and flag is 0. `irq_req`, `start` and `unit_reset` are 0.
- R2: A write with bit 0 (GO) set while ready is 1 produces a `start` pulse one cycle long, in the cycle after the write. The pulse carries the operation code from bits 3-1 (0 off line, 1 read, 2 write, 3 write end-of-file, 4 space forward, 5 space reverse, 6 write with long gap, 7 rewind), the unit from bits 9-8 and the formatter from bit 10. Ready drops to 0 at the same time.
- R3: While ready is 0, a GO write produces no start pulse. Unit, formatter, operation code and address bits keep their values. Only bit 6 (enable) is taken from such a write.
- R4: An `op_done` pulse while busy sets ready back to 1 in the next cycle.
- R5: The error flag (read bit 15) sets when any bit of `stat_err` is 1 and stays set. An accepted GO clears it.
- R6: The read layout is: bit 15 error, bit 10 formatter, bits 9-8 unit, bit 7 ready, bit 6 enable, bits 5-4 address extension, bits 3-1 operation code. Bits 0 and 11-14 always read 0, including power clear in bit 12.
- R7: With the enable set, ready going from 0 to 1 raises `irq_req` one cycle after ready is seen high.
- R8: With the enable set, the error flag going from 0 to 1 raises `irq_req` one cycle after the flag is seen high.
- R9: With the enable set, a pulse on any bit of `bot_hit` raises `irq_req` in the next cycle.
- R10: A write with GO clear that moves the enable from 0 to 1 while ready or error is 1 raises `irq_req` in the next cycle. The same write made while the enable is already 1, or made with GO set, raises nothing.
- R11: `irq_req` holds until `irq_ack` is pulsed. Further events while it is pending leave one request, and one acknowledge clears it.
- R12: A write with bit 12 set restores the R1 state, clears `irq_req`, pulses `unit_reset` for one cycle and starts nothing, even when GO is also set.
- R13: With the enable clear, no event raises `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | Bus initialise pulse, clears the register state |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value |
| op_done | input | 1 | Operation-complete pulse from the sequencer |
| stat_err | input | ERR_W | Status error conditions |
| bot_hit | input | NUM_UNITS | Per-unit pulse: a rewinding unit reached beginning-of-tape |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| start | output | 1 | One-cycle operation start pulse |
| start_func | output | 3 | Operation code that goes with `start` |
| start_unit | output | 2 | Unit that goes with `start` |
| start_fmt | output | 1 | Formatter select that goes with `start` |
| unit_reset | output | 1 | One-cycle power-clear pulse to the units |
| irq_req | output | 1 | Interrupt request |

## Verification
Assertions check several relations on every cycle:
- a start pulse is never seen while ready is 1 or while the error flag is set;
- ready rises only after a completion or a clear;
- a busy GO write is never followed by a start;
- the request rises only with the enable set and drops only after an acknowledge or a clear.

Only the directed scenarios can show the rest: that the start pulse carries the right field values, that the cause of each interrupt appears at the right cycle, that an armed-enable write or an event is missed when it should not be, and that the read layout is correct.

// File: rtl/tape_cmd_pkg.sv
// Shared layout and types for the tape command register.
// Assumes the 16-bit field positions are fixed because software decodes them.
package tape_cmd_pkg;
    localparam int GO_BIT   = 0;
    localparam int FN_LO    = 1;
    localparam int FN_W     = 3;
    localparam int XA_LO    = 4;
    localparam int XA_W     = 2;
    localparam int IE_BIT   = 6;
    localparam int RDY_BIT  = 7;
    localparam int UNIT_LO  = 8;
    localparam int UNIT_W   = 2;
    localparam int FMT_BIT  = 10;
    localparam int PCLR_BIT = 12;
    localparam int ERR_BIT  = 15;
    localparam int REG_W    = 16;

    typedef enum logic [FN_W-1:0] {
        FN_OFFLINE = 3'd0,
        FN_READ    = 3'd1,
        FN_WRITE   = 3'd2,
        FN_WEOF    = 3'd3,
        FN_SPFWD   = 3'd4,
        FN_SPREV   = 3'd5,
        FN_WXGAP   = 3'd6,
        FN_REWIND  = 3'd7
    } tape_fn_e;

    typedef struct packed {
        logic              fmt;
        logic [UNIT_W-1:0] unit;
        logic              ie;
        logic [XA_W-1:0]   xaddr;
        tape_fn_e          fn;
    } cmd_fields_t;
endpackage

// File: rtl/tape_cmd_decode.sv
// Splits a register write into fields and strobes.
// Assumes wr_data is valid whenever wr_en is high, and that ready and ie_cur
// are the current register values.
module tape_cmd_decode
    import tape_cmd_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ready,
    input  logic             ie_cur,
    output cmd_fields_t      fields,
    output logic             field_we,
    output logic             ie_we,
    output logic             go_req,
    output logic             pclr_req,
    output logic             ie_arm_req
);
    // Extract the fields and derive the strobes for this write.
    always_comb begin
        fields.fmt   = wr_data[FMT_BIT];
        fields.unit  = wr_data[UNIT_LO +: UNIT_W];
        fields.ie    = wr_data[IE_BIT];
        fields.xaddr = wr_data[XA_LO +: XA_W];
        fields.fn    = tape_fn_e'(wr_data[FN_LO +: FN_W]);
        pclr_req     = wr_en & wr_data[PCLR_BIT];
        ie_we        = wr_en & ~wr_data[PCLR_BIT];
        field_we     = ie_we & ready;
        go_req       = field_we & wr_data[GO_BIT];
        ie_arm_req   = ie_we & ~wr_data[GO_BIT] & wr_data[IE_BIT] & ~ie_cur;
    end
endmodule

// File: rtl/tape_cmd_regs.sv
// Holds the command fields, the ready and error flags, and the start and
// unit-reset pulses. Assumes op_done arrives only while an operation runs.
module tape_cmd_regs
    import tape_cmd_pkg::*;
#(
    parameter int ERR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  cmd_fields_t      fields,
    input  logic             field_we,
    input  logic             ie_we,
    input  logic             go_req,
    input  logic             pclr_req,
    input  logic             op_done,
    input  logic [ERR_W-1:0] stat_err,
    output cmd_fields_t      cur,
    output logic             ready_q,
    output logic             err_q,
    output logic             start_q,
    output logic             unit_rst_q
);
    // Command fields: all of them are writable when ready, only the enable when busy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cur <= '0;
        end else if (field_we) begin
            cur <= fields;
        end else if (ie_we) begin
            cur.ie <= fields.ie;
        end
    end

    // Ready, error and start sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ready_q <= 1'b1;
            err_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= go_req;
            if (go_req) begin
                ready_q <= 1'b0;
            end else if (op_done) begin
                ready_q <= 1'b1;
            end
            err_q <= go_req ? 1'b0 : (err_q | (|stat_err));
        end
    end

    // Power-clear pulse to the units.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_rst_q <= 1'b0;
        end else begin
            unit_rst_q <= pclr_req;
        end
    end

    // R2
    start_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> !ready_q);
    // R4
    ready_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(op_done || clr));
    // R5
    start_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> !err_q);
    // R12
    unit_rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_rst_q |-> (ready_q && !start_q));
endmodule

// File: rtl/tape_irq_gen.sv
// Single pending interrupt request, built from level edges, unit pulses and
// the armed-enable write. Assumes ready and err are register outputs.
module tape_irq_gen #(
    parameter int NUM_UNITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 ie,
    input  logic                 ready,
    input  logic                 err,
    input  logic [NUM_UNITS-1:0] bot_hit,
    input  logic                 ie_arm_req,
    input  logic                 ack,
    output logic                 irq_q
);
    logic rdy_prev;
    logic err_prev;
    logic evt;

    // Delayed copies used to detect rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rdy_prev <= 1'b1;
            err_prev <= 1'b0;
        end else begin
            rdy_prev <= ready;
            err_prev <= err;
        end
    end

    // Combine every interrupt cause.
    always_comb begin
        evt = (ie & ((ready & ~rdy_prev) | (err & ~err_prev) | (|bot_hit)))
            | (ie_arm_req & (ready | err));
    end

    // Request flag: set by an event, held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            irq_q <= 1'b0;
        end else if (evt) begin
            irq_q <= 1'b1;
        end else if (ack) begin
            irq_q <= 1'b0;
        end
    end

    // R13
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> ie);
    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> $past(ack || clr));
endmodule

// File: rtl/tape_cmd_ctl.sv
// Top of the tape command register: decode, register state, interrupt, and
// the assembly of the read value. Assumes one write per cycle at most.
module tape_cmd_ctl
    import tape_cmd_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int ERR_W     = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init,
    input  logic                 wr_en,
    input  logic [15:0]          wr_data,
    output logic [15:0]          rd_data,
    input  logic                 op_done,
    input  logic [ERR_W-1:0]     stat_err,
    input  logic [NUM_UNITS-1:0] bot_hit,
    input  logic                 irq_ack,
    output logic                 start,
    output logic [2:0]           start_func,
    output logic [1:0]           start_unit,
    output logic                 start_fmt,
    output logic                 unit_reset,
    output logic                 irq_req
);
    cmd_fields_t fields;
    cmd_fields_t cur;
    logic field_we, ie_we, go_req, pclr_req, ie_arm_req;
    logic ready_q, err_q, clr;

    assign clr = init | pclr_req;

    tape_cmd_decode u_dec (
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ready      (ready_q),
        .ie_cur     (cur.ie),
        .fields     (fields),
        .field_we   (field_we),
        .ie_we      (ie_we),
        .go_req     (go_req),
        .pclr_req   (pclr_req),
        .ie_arm_req (ie_arm_req)
    );

    tape_cmd_regs #(.ERR_W(ERR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .fields     (fields),
        .field_we   (field_we),
        .ie_we      (ie_we),
        .go_req     (go_req),
        .pclr_req   (pclr_req),
        .op_done    (op_done),
        .stat_err   (stat_err),
        .cur        (cur),
        .ready_q    (ready_q),
        .err_q      (err_q),
        .start_q    (start),
        .unit_rst_q (unit_reset)
    );

    tape_irq_gen #(.NUM_UNITS(NUM_UNITS)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .ie         (cur.ie),
        .ready      (ready_q),
        .err        (err_q),
        .bot_hit    (bot_hit),
        .ie_arm_req (ie_arm_req),
        .ack        (irq_ack),
        .irq_q      (irq_req)
    );

    // Start attributes come from the stored fields.
    assign start_func = cur.fn;
    assign start_unit = cur.unit;
    assign start_fmt  = cur.fmt;

    // Assemble the read value. GO and power clear are not stored.
    always_comb begin
        rd_data                      = '0;
        rd_data[ERR_BIT]             = err_q;
        rd_data[FMT_BIT]             = cur.fmt;
        rd_data[UNIT_LO +: UNIT_W]   = cur.unit;
        rd_data[RDY_BIT]             = ready_q;
        rd_data[IE_BIT]              = cur.ie;
        rd_data[XA_LO +: XA_W]       = cur.xaddr;
        rd_data[FN_LO +: FN_W]       = cur.fn;
    end

    // R3
    busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[GO_BIT] && !ready_q && !wr_data[PCLR_BIT]) |=> !start);
endmodule

// File: tb/sim_tape_cmd_ctl.sv
`timescale 1ns/1ps
module sim_tape_cmd_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        op_done = 1'b0;
    logic [8:0]  stat_err = '0;
    logic [3:0]  bot_hit = '0;
    logic        irq_ack = 1'b0;
    logic        start;
    logic [2:0]  start_func;
    logic [1:0]  start_unit;
    logic        start_fmt;
    logic        unit_reset;
    logic        irq_req;
    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    tape_cmd_ctl u0 (
        .clk(clk), .rst_n(rst_n), .init(init), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .op_done(op_done), .stat_err(stat_err), .bot_hit(bot_hit),
        .irq_ack(irq_ack), .start(start), .start_func(start_func),
        .start_unit(start_unit), .start_fmt(start_fmt), .unit_reset(unit_reset),
        .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic done_pulse();
        op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 read after reset", rd_data, 16'h0080);
        check("R1 irq after reset", irq_req, 0);
        check("R1 start after reset", start, 0);
        check("R1 unit_reset after reset", unit_reset, 0);
    endtask

    task automatic t_go_busy();
        wr(16'h0705);
        check("R2 start pulse", start, 1);
        check("R2 start func", start_func, 3'd2);
        check("R2 start unit", start_unit, 2'd3);
        check("R2 start fmt", start_fmt, 1);
        check("R6 read busy", rd_data, 16'h0704);
        @(negedge clk);
        check("R2 start one cycle", start, 0);
        wr(16'h0103);
        check("R3 busy GO no start", start, 0);
        check("R3 busy fields kept", rd_data, 16'h0704);
        wr(16'h0040);
        check("R3 busy enable writable", rd_data, 16'h0744);
        check("R10 no arm irq when busy", irq_req, 0);
        done_pulse();
        check("R4 ready after done", rd_data, 16'h07C4);
        check("R7 irq not yet", irq_req, 0);
        @(negedge clk);
        check("R7 irq on ready rise", irq_req, 1);
        @(negedge clk);
        check("R11 irq held", irq_req, 1);
        ack_pulse();
        check("R11 ack clears", irq_req, 0);
    endtask

    task automatic t_err();
        stat_err = 9'h004; @(negedge clk); stat_err = '0;
        check("R5 error flag set", rd_data[15], 1);
        check("R8 irq not yet", irq_req, 0);
        @(negedge clk);
        check("R8 irq on error rise", irq_req, 1);
        check("R5 error sticky", rd_data[15], 1);
        bot_hit = 4'b0001; @(negedge clk); bot_hit = '0;
        ack_pulse();
        check("R11 single pending", irq_req, 0);
        wr(16'h0043);
        check("R5 GO clears error", rd_data, 16'h0042);
        check("R5 GO start", start, 1);
        done_pulse(); @(negedge clk);
        check("R7 irq after op", irq_req, 1);
        ack_pulse();
    endtask

    task automatic t_bot();
        bot_hit = 4'b0100; @(negedge clk); bot_hit = '0;
        check("R9 irq on bot", irq_req, 1);
        ack_pulse();
        check("R11 ack after bot", irq_req, 0);
    endtask

    task automatic t_arm();
        wr(16'h0000);
        wr(16'h0040);
        check("R10 arm irq", irq_req, 1);
        ack_pulse();
        wr(16'h0040);
        @(negedge clk);
        check("R10 no irq already enabled", irq_req, 0);
        wr(16'h0000);
        wr(16'h0041);
        check("R10 no arm irq with GO", irq_req, 0);
        done_pulse(); @(negedge clk);
        check("R7 irq after armed GO", irq_req, 1);
        ack_pulse();
    endtask

    task automatic t_no_ie();
        wr(16'h0000);
        bot_hit = 4'b1000; @(negedge clk); bot_hit = '0;
        check("R13 no irq bot", irq_req, 0);
        wr(16'h0001);
        done_pulse(); @(negedge clk);
        stat_err = 9'h100; @(negedge clk); stat_err = '0; @(negedge clk);
        check("R13 no irq ready/err", irq_req, 0);
        check("R13 error still latched", rd_data, 16'h8080);
    endtask

    task automatic t_pclr();
        wr(16'h0346);
        bot_hit = 4'b0010; @(negedge clk); bot_hit = '0;
        check("R9 irq before pclr", irq_req, 1);
        wr(16'h1001);
        check("R12 unit_reset pulse", unit_reset, 1);
        check("R12 no start", start, 0);
        check("R12 read cleared", rd_data, 16'h0080);
        check("R12 irq cleared", irq_req, 0);
        @(negedge clk);
        check("R12 unit_reset one cycle", unit_reset, 0);
    endtask

    task automatic t_init_layout();
        wr(16'h0270);
        check("R6 address bits readback", rd_data, 16'h02F0);
        wr(16'h6800);
        check("R6 unused bits read zero", rd_data, 16'h0080);
        wr(16'h0271);
        init = 1'b1; @(negedge clk); init = 1'b0;
        check("R1 init clears", rd_data, 16'h0080);
    endtask

    task automatic t_fn();
        for (int f = 0; f < 8; f++) begin
            wr(16'(f << 1) | 16'h0001);
            check("R2 func code", {start, start_func}, {1'b1, 3'(f)});
            done_pulse();
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_go_busy();
        t_err();
        t_bot();
        t_arm();
        t_no_ie();
        t_pclr();
        t_init_layout();
        t_fn();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule